// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Controller

This block sits between a group of interrupt sources and a small CPU core. Each vector collects several request lines that are ORed together, and carries an enable bit and a level-select bit. Software chooses one of two levels for each vector. The first vectors can be set to low or highest, and the remaining vectors to low or high. The controller keeps the level currently in service on a short nesting stack.

A request is taken only when its level is strictly above the level in service. When a request is taken, the controller emits a one-cycle take strobe together with the winning vector address, and it pushes the new level onto the stack. A return-from-interrupt pulse pops the stack and restores the previous level. Clearing the source flags is left to the peripherals.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, take_o is 0, cur_lvl_o is 0 (idle) and vec_addr_o is 0.
- R2: The level encoding on cur_lvl_o is 0 idle, 1 low, 2 high and 3 highest. A vector with vec_hi clear is low. A vector with vec_hi set is highest if its index is below TOP_VECS (vectors 0 and 1 by default), and high otherwise.
- R3: Vector v requests when any of its LINES lines irq_lines[v*LINES +: LINES] is 1.
- R4: A vector whose vec_en bit is 0 is never taken, whatever its lines do.
- R5: A request is taken only if its level is strictly greater than cur_lvl_o. A request at a level equal to or below cur_lvl_o produces no take.
- R6: Among eligible vectors the highest level wins. Among vectors of the same level, the smallest index wins.
- R7: At a take, vec_addr_o equals 0x0003 + 8 * index, so vector 0 is 0x0003 and vector 8 is 0x0043. vec_addr_o holds its value between takes.
- R8: take_o, vec_addr_o and cur_lvl_o change one clock edge after the request is seen. take_o lasts a single cycle. In the cycle after a take, pending requests are judged against the new level.
- R9: A reti_i pulse while the controller is not idle restores the level that was in service before the last take. Up to three nested levels are kept. No take occurs in a cycle that pops.
- R10: A reti_i pulse while idle is ignored: the level stays 0 and no take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_VEC*LINES | Source request lines, LINES lines per vector |
| vec_en | input | NUM_VEC | Per-vector enable |
| vec_hi | input | NUM_VEC | Per-vector level select (see R2) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle take strobe |
| vec_addr_o | output | ADDR_W | Winning vector address |
| cur_lvl_o | output | 2 | Level in service |

## Verification
The bench targets equal-level requests arriving while that level is in service. A design using a greater-or-equal comparison would retake them on every cycle. Simultaneous requests at one level test the tie rule: a reversed priority scan would pick the largest address. Nesting three deep and then unwinding shows whether the stack restores each earlier level, or whether a flat register drops straight to idle. Returns while idle, and returns that coincide with a new request, expose a stack underflow or a take judged against the stale level.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NUM_VEC  = 9,
  parameter int LINES    = 3,
  parameter int TOP_VECS = 2,
  parameter int STK_D    = 3,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VEC*LINES-1:0] irq_lines,
  input  logic [NUM_VEC-1:0]       vec_en,
  input  logic [NUM_VEC-1:0]       vec_hi,
  input  logic                     reti_i,
  output logic                     take_o,
  output logic [ADDR_W-1:0]        vec_addr_o,
  output logic [1:0]               cur_lvl_o
);
  localparam int IDX_W = $clog2(NUM_VEC);
  localparam logic [1:0] L_IDLE = 2'd0, L_LOW = 2'd1, L_HIGH = 2'd2, L_TOP = 2'd3;

  logic [NUM_VEC-1:0] req;
  logic [1:0]         vlvl [NUM_VEC];
  logic [1:0]         cur;
  logic [1:0]         stk  [STK_D];
  logic [1:0]         win_lvl;
  logic [IDX_W-1:0]   win_idx;
  logic               pop, hit;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [1:0] HI_LVL = (v < TOP_VECS) ? L_TOP : L_HIGH;
    assign req[v]  = |irq_lines[v*LINES +: LINES] & vec_en[v];
    assign vlvl[v] = vec_hi[v] ? HI_LVL : L_LOW;
  end

  always_comb begin
    win_lvl = L_IDLE;
    win_idx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (req[v] && vlvl[v] > cur && vlvl[v] >= win_lvl) begin
        win_lvl = vlvl[v];
        win_idx = IDX_W'(v);
      end
    end
  end

  assign pop = reti_i && cur != L_IDLE;
  assign hit = !reti_i && win_lvl != L_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= L_IDLE;
      take_o     <= 1'b0;
      vec_addr_o <= '0;
      for (int i = 0; i < STK_D; i++) stk[i] <= L_IDLE;
    end else begin
      take_o <= hit;
      if (pop) begin
        cur <= stk[0];
        for (int i = 0; i < STK_D - 1; i++) stk[i] <= stk[i+1];
        stk[STK_D-1] <= L_IDLE;
      end else if (hit) begin
        cur        <= win_lvl;
        vec_addr_o <= ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);
        stk[0]     <= cur;
        for (int i = 1; i < STK_D; i++) stk[i] <= stk[i-1];
      end
    end
  end

  assign cur_lvl_o = cur;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int NUM_VEC  = 9,
  parameter int LINES    = 3,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_VEC*LINES-1:0] irq_lines,
  input logic [NUM_VEC-1:0]       vec_en,
  input logic [NUM_VEC-1:0]       vec_hi,
  input logic                     reti_i,
  input logic                     take_o,
  input logic [ADDR_W-1:0]        vec_addr_o,
  input logic [1:0]               cur_lvl_o
);
  logic [NUM_VEC-1:0] en_d;
  logic [ADDR_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_d <= '0;
    else        en_d <= vec_en;

  assign idx = (vec_addr_o - ADDR_W'(VEC_BASE)) / ADDR_W'(VEC_STEP);

  assert_take_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cur_lvl_o > $past(cur_lvl_o));

  assert_take_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o || cur_lvl_o > $past(cur_lvl_o));

  assert_lvl_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl_o != $past(cur_lvl_o)) |-> take_o || $past(reti_i));

  assert_addr_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((vec_addr_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == 0
               && idx < ADDR_W'(NUM_VEC));

  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && idx < ADDR_W'(NUM_VEC)) |-> en_d[idx]);

  assert_pop_lowers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && cur_lvl_o != 2'd0) |=> cur_lvl_o < $past(cur_lvl_o) && !take_o);

  assert_idle_reti_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && cur_lvl_o == 2'd0) |=> cur_lvl_o == 2'd0 && !take_o);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
  .NUM_VEC(NUM_VEC), .LINES(LINES), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (.*);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  localparam int NV = 9, NL = 3;
  logic clk = 0, rst_n = 0, reti = 0;
  logic [NV*NL-1:0] lines = '0;
  logic [NV-1:0] en = '0, hi = '0;
  logic take;
  logic [15:0] addr;
  logic [1:0] lvl;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_lines(lines), .vec_en(en),
    .vec_hi(hi), .reti_i(reti), .take_o(take), .vec_addr_o(addr), .cur_lvl_o(lvl));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic expect_st(string r, logic t, logic [1:0] l, logic [15:0] a);
    chk({r, " take"}, 32'(take), 32'(t));
    chk({r, " level"}, 32'(lvl), 32'(l));
    chk({r, " addr"}, 32'(addr), 32'(a));
  endtask

  task automatic do_reset();
    rst_n = 0; lines = '0; en = '0; hi = '0; reti = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic pulse_reti();
    reti = 1; step(); reti = 0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_st("R1", 0, 0, 16'h0000);
  endtask

  task automatic t_single_low();
    do_reset();
    en = '1;
    lines[4*NL+2] = 1; step();
    expect_st("R7 R8", 1, 1, 16'h0023);
    step();
    expect_st("R5 R8 same level not retaken", 0, 1, 16'h0023);
    lines = '0; pulse_reti();
    expect_st("R9", 0, 0, 16'h0023);
  endtask

  task automatic t_or_lines();
    do_reset();
    en = '1;
    lines[2*NL+1] = 1; step();
    expect_st("R3 line1", 1, 1, 16'h0013);
    lines = '0; pulse_reti(); step();
    lines[2*NL+2] = 1; step();
    expect_st("R3 line2", 1, 1, 16'h0013);
  endtask

  task automatic t_disabled();
    do_reset();
    en = '1; en[0] = 0; hi[0] = 1;
    lines[0*NL] = 1;
    step(); step(); step();
    expect_st("R4", 0, 0, 16'h0000);
  endtask

  task automatic t_priority();
    do_reset();
    en = '1; hi[5] = 1; hi[3] = 1;
    lines[5*NL] = 1; lines[3*NL] = 1; lines[7*NL] = 1; step();
    expect_st("R6 high beats low, smallest high", 1, 2, 16'h001B);
    do_reset();
    en = '1;
    lines[8*NL] = 1; lines[6*NL+1] = 1; step();
    expect_st("R6 low tie", 1, 1, 16'h0033);
    do_reset();
    en = '1; hi[1] = 1;
    lines[0] = 1; lines[1*NL] = 1; step();
    expect_st("R6 highest beats low at smaller index", 1, 3, 16'h000B);
  endtask

  task automatic t_levels();
    do_reset();
    en = '1; hi[5] = 1;
    lines[5*NL] = 1; step();
    expect_st("R2 hi on later vector is high", 1, 2, 16'h002B);
    do_reset();
    en = '1; hi[0] = 1;
    lines[0] = 1; step();
    expect_st("R2 hi on first vector is highest", 1, 3, 16'h0003);
  endtask

  task automatic t_nesting();
    do_reset();
    en = '1; hi[3] = 1; hi[0] = 1; hi[2] = 1;
    lines[4*NL] = 1; step();
    expect_st("R9 nest1", 1, 1, 16'h0023);
    lines[3*NL] = 1; step();
    expect_st("R8 nest2 next cycle", 1, 2, 16'h001B);
    lines[0] = 1; step();
    expect_st("R9 nest3", 1, 3, 16'h0003);
    lines[2*NL] = 1; step(); step();
    expect_st("R5 high blocked under highest", 0, 3, 16'h0003);
    lines = '0;
    pulse_reti(); expect_st("R9 pop to high", 0, 2, 16'h0003);
    pulse_reti(); expect_st("R9 pop to low", 0, 1, 16'h0003);
    pulse_reti(); expect_st("R9 pop to idle", 0, 0, 16'h0003);
  endtask

  task automatic t_reti_corner();
    do_reset();
    pulse_reti();
    expect_st("R10 idle reti", 0, 0, 16'h0000);
    en = '1; hi[6] = 1;
    lines[1*NL] = 1; step();
    expect_st("R9 setup", 1, 1, 16'h000B);
    lines = '0; lines[6*NL] = 1;
    pulse_reti();
    expect_st("R9 no take while popping", 0, 0, 16'h000B);
    step();
    expect_st("R9 take after pop", 1, 2, 16'h0033);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_low();
    t_or_lines();
    t_disabled();
    t_priority();
    t_levels();
    t_nesting();
    t_reti_corner();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule